// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Channel

This block moves an incoming byte stream into memory, one receive channel at a time. Software prepares a ring of descriptors in memory. Each descriptor names a buffer and its length, and it carries an ownership flag. The channel reads the descriptor at its current ring position. It accepts a descriptor only when the flag hands it to hardware. It then writes received bytes one by one into that buffer.

A buffer is closed by whichever happens first: the stream marks the end of a packet, or the buffer's byte budget runs out. When a buffer closes, the channel writes a status word back into the descriptor. That word returns ownership to software and records how many bytes were stored and whether the packet ended there. The channel then moves to the next ring slot. If software still owns the current slot, the channel re-reads it on a fixed period and holds the stream back. Software may also request an immediate re-read.

Top module: `rxdma_channel`

## Requirements
- R1: While reset is asserted, and one cycle after `enable` is low, `mem_req` and `in_ready` are 0.
- R2: After `enable` rises, the first memory access is a word read of the descriptor at `ring_base`, which is ring slot 0.
- R3: Descriptor i occupies two 32-bit words at `ring_base + 8*i`. In the first word, bit 31 is the hardware-ownership flag and bits 15:0 are the buffer length in bytes. The second word, at offset 4, holds the buffer byte address in its low `ADDR_W` bits.
- R4: While the current descriptor has bit 31 clear, the channel does not advance and holds `in_ready` at 0. It re-reads that descriptor word once every `POLL_CYCLES` cycles, plus the access time.
- R5: A one-cycle pulse on `poll_kick` while the channel waits on a software-owned descriptor starts the re-read at once.
- R6: Each accepted byte is stored with a byte write (`mem_we`=1, `mem_byte`=1, data in `mem_wdata[7:0]`, upper bits 0). Successive bytes of a buffer go to successive addresses starting at the buffer address. `in_ready` is never 1 while a memory access is pending.
- R7: When a buffer closes, the channel writes the first descriptor word (`mem_byte`=0) with bit 31 = 0, bit 30 = 1 if the last stored byte ended a packet, bits 15:0 = bytes stored, and all other bits 0.
- R8: If the byte budget runs out before the end of a packet, the status word has bit 30 = 0. The rest of the packet continues in the next owned descriptor.
- R9: After the status write of slot `NUM_DESC-1`, the next descriptor read is slot 0.
- R10: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle `mem_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel run; low returns to idle at ring slot 0 |
| poll_kick | input | 1 | Request an immediate descriptor re-read |
| ring_base | input | ADDR_W | Byte address of ring slot 0 |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte ends a packet |
| in_ready | output | 1 | Channel takes the byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = byte write, 0 = 32-bit word access |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle (read data valid) |
| mem_rdata | input | 32 | Read data |

## Verification
The stream is driven with packets that fit inside a buffer and with a packet that fills its buffer exactly while carrying the end mark. These two cases separate closing on the end mark from closing on the budget. A packet longer than its buffer is split across a descriptor that software still owns. This case tells apart correct stalling and periodic polling from dropped or misplaced bytes, and it shows the forced re-read against the slow poll. A final packet after the ring has wrapped shows that slot 0 is reused at its original buffer address. Memory acknowledge latency varies between zero and two cycles, so request holding is exercised throughout.

// File: rtl/rxdma_pkg.sv
// Shared constants, state type and status-word helper for the receive DMA channel.
package rxdma_pkg;

    localparam int LEN_W       = 16;  // length and count field width
    localparam int OWN_BIT     = 31;  // hardware-ownership flag position
    localparam int END_BIT     = 30;  // packet-ended flag position
    localparam int DESC_STRIDE = 8;   // bytes per descriptor
    localparam int PTR_OFFSET  = 4;   // offset of the buffer-address word

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_HDR,
        ST_FETCH_PTR,
        ST_POLL_WAIT,
        ST_ACCEPT,
        ST_STORE,
        ST_WRITEBACK
    } rx_state_t;

    // Builds the status word returned to software when a buffer closes.
    function automatic logic [31:0] status_word(input logic ended, input logic [LEN_W-1:0] count);
        logic [31:0] w;
        w          = '0;
        w[END_BIT] = ended;
        w[LEN_W-1:0] = count;
        return w;
    endfunction

endpackage

// File: rtl/rxdma_poll_timer.sv
// Poll interval timer.
// Loads POLL_CYCLES on arm and counts down to zero. It reports expiry at zero,
// or at once when a kick arrives. The caller only looks at expiry while waiting.
module rxdma_poll_timer #(
    parameter int POLL_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic kick,
    output logic expired
);
    localparam int CNT_W = $clog2(POLL_CYCLES + 1);

    logic [CNT_W-1:0] count;

    // Reload on arm, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (arm)
            count <= CNT_W'(POLL_CYCLES);
        else if (count != '0)
            count <= count - 1'b1;
    end

    // Expiry on reaching zero or on a forced poll.
    always_comb expired = (count == '0) || kick;

endmodule

// File: rtl/rxdma_ring_ptr.sv
// Ring position tracker.
// Holds the current descriptor index and wraps from NUM_DESC-1 back to 0.
// It derives the addresses of both descriptor words from the ring base.
module rxdma_ring_ptr #(
    parameter int ADDR_W   = 16,
    parameter int NUM_DESC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [ADDR_W-1:0] ring_base,
    output logic [ADDR_W-1:0] hdr_addr,
    output logic [ADDR_W-1:0] ptr_addr
);
    import rxdma_pkg::*;

    localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

    logic [IDX_W-1:0] idx;

    // Index register: clear, or step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            idx <= '0;
        else if (advance)
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
    end

    // Word addresses of the current descriptor.
    always_comb begin
        hdr_addr = ring_base + ADDR_W'(idx) * ADDR_W'(DESC_STRIDE);
        ptr_addr = hdr_addr + ADDR_W'(PTR_OFFSET);
    end

endmodule

// File: rtl/rxdma_buf_track.sv
// Per-buffer bookkeeping.
// Holds the destination address, the remaining byte budget (terminal count) and
// the bytes stored so far. A length load also clears the stored count.
module rxdma_buf_track #(
    parameter int ADDR_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_len,
    input  logic [rxdma_pkg::LEN_W-1:0] len_in,
    input  logic                       load_addr,
    input  logic [ADDR_W-1:0]          addr_in,
    input  logic                       step,
    output logic [ADDR_W-1:0]          cur_addr,
    output logic [rxdma_pkg::LEN_W-1:0] remaining,
    output logic [rxdma_pkg::LEN_W-1:0] stored
);
    // Budget and stored count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            stored    <= '0;
        end else if (load_len) begin
            remaining <= len_in;
            stored    <= '0;
        end else if (step) begin
            remaining <= remaining - 1'b1;
            stored    <= stored + 1'b1;
        end
    end

    // Destination address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (load_addr)
            cur_addr <= addr_in;
        else if (step)
            cur_addr <= cur_addr + 1'b1;
    end

endmodule

// File: rtl/rxdma_channel.sv
// Descriptor-ring receive DMA channel (top).
// Fetches descriptors, polls those owned by software, and stores stream bytes
// into owned buffers. It closes each buffer on packet end or when the budget runs
// out, and writes a status word back.
// Assumes a memory that holds a request until mem_ack and returns read data with it.
module rxdma_channel #(
    parameter int ADDR_W      = 16,
    parameter int NUM_DESC    = 4,
    parameter int POLL_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              poll_kick,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    import rxdma_pkg::*;

    rx_state_t         state, state_nx;
    logic [7:0]        byte_q;
    logic              last_q;
    logic              ended_q, ended_nx;
    logic              timer_arm, timer_expired;
    logic              ring_advance;
    logic [ADDR_W-1:0] hdr_addr, ptr_addr;
    logic              load_len, load_addr, step;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remaining, stored;
    logic              rdata_unused;

    assign rdata_unused = ^mem_rdata;

    rxdma_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .arm(timer_arm),
        .kick(poll_kick), .expired(timer_expired)
    );

    rxdma_ring_ptr #(.ADDR_W(ADDR_W), .NUM_DESC(NUM_DESC)) ring_i (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_IDLE),
        .advance(ring_advance), .ring_base(ring_base),
        .hdr_addr(hdr_addr), .ptr_addr(ptr_addr)
    );

    rxdma_buf_track #(.ADDR_W(ADDR_W)) buf_i (
        .clk(clk), .rst_n(rst_n),
        .load_len(load_len), .len_in(mem_rdata[LEN_W-1:0]),
        .load_addr(load_addr), .addr_in(mem_rdata[ADDR_W-1:0]),
        .step(step), .cur_addr(cur_addr),
        .remaining(remaining), .stored(stored)
    );

    // Next-state and control strobes of the channel sequencer.
    always_comb begin
        state_nx     = state;
        ended_nx     = ended_q;
        timer_arm    = 1'b0;
        ring_advance = 1'b0;
        load_len     = 1'b0;
        load_addr    = 1'b0;
        step         = 1'b0;
        unique case (state)
            ST_IDLE:      state_nx = ST_FETCH_HDR;
            ST_FETCH_HDR: if (mem_ack) begin
                if (mem_rdata[OWN_BIT]) begin
                    load_len = 1'b1;
                    state_nx = ST_FETCH_PTR;
                end else begin
                    timer_arm = 1'b1;
                    state_nx  = ST_POLL_WAIT;
                end
            end
            ST_FETCH_PTR: if (mem_ack) begin
                load_addr = 1'b1;
                ended_nx  = 1'b0;
                state_nx  = (remaining == '0) ? ST_WRITEBACK : ST_ACCEPT;
            end
            ST_POLL_WAIT: if (timer_expired) state_nx = ST_FETCH_HDR;
            ST_ACCEPT:    if (in_valid) state_nx = ST_STORE;
            ST_STORE:     if (mem_ack) begin
                step = 1'b1;
                if (last_q) begin
                    ended_nx = 1'b1;
                    state_nx = ST_WRITEBACK;
                end else if (remaining == LEN_W'(1)) begin
                    ended_nx = 1'b0;
                    state_nx = ST_WRITEBACK;
                end else begin
                    state_nx = ST_ACCEPT;
                end
            end
            ST_WRITEBACK: if (mem_ack) begin
                ring_advance = 1'b1;
                state_nx     = ST_FETCH_HDR;
            end
            default:      state_nx = ST_IDLE;
        endcase
        if (!enable) state_nx = ST_IDLE;
    end

    // State, packet-end flag and captured stream byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ended_q <= 1'b0;
            byte_q  <= '0;
            last_q  <= 1'b0;
        end else begin
            state   <= state_nx;
            ended_q <= ended_nx;
            if (state == ST_ACCEPT && in_valid) begin
                byte_q <= in_data;
                last_q <= in_last;
            end
        end
    end

    // Memory port and stream handshake decode.
    always_comb begin
        in_ready  = (state == ST_ACCEPT);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_byte  = 1'b0;
        mem_addr  = hdr_addr;
        mem_wdata = '0;
        unique case (state)
            ST_FETCH_HDR: mem_req = 1'b1;
            ST_FETCH_PTR: begin
                mem_req  = 1'b1;
                mem_addr = ptr_addr;
            end
            ST_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_byte  = 1'b1;
                mem_addr  = cur_addr;
                mem_wdata = {24'b0, byte_q};
            end
            ST_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = status_word(ended_q, stored);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rxdma_channel_chk.sv
// Protocol checker for the receive DMA channel, bound to every instance.
// Assumes nothing beyond the top-level ports.
module rxdma_channel_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              in_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_byte,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack
);
    // R10: a pending access holds its request and fields.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && enable) |=> (mem_req && $stable(mem_addr)
            && $stable(mem_we) && $stable(mem_wdata)));

    // R1: a low enable quiets both interfaces on the next cycle.
    a_r1_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!mem_req && !in_ready));

    // R6: no stream byte is taken while memory is busy.
    a_r6_ready_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mem_req);

    // R6: byte stores are writes with clean upper data.
    a_r6_byte_store_form: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_byte) |-> (mem_we && mem_wdata[31:8] == 24'b0));

    // R7: status write-back always hands ownership to software.
    a_r7_status_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_byte) |-> !mem_wdata[31]);

endmodule

bind rxdma_channel rxdma_channel_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/rxdma_channel_tb_top.sv
// Scoreboard bench for the receive DMA channel.
module rxdma_channel_tb_top;
    localparam int ADDR_W = 16;
    localparam int POLL   = 200;
    localparam logic [15:0] RING = 16'h0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, poll_kick = 1'b0;
    logic [ADDR_W-1:0] ring_base = RING;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, mem_req, mem_we, mem_byte, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    int errors = 0, checks = 0;
    int slot2_reads = 0, txn = 0;
    logic first_seen = 1'b0;
    logic [15:0] first_addr = '0;
    logic first_we = 1'b0;
    logic [7:0] mem_b [0:1023];
    logic [23:0] exp_q[$];
    logic [15:0] bq_addr[$];
    int bq_len[$];
    int cur_off = 0;

    always #10 clk = ~clk;

    rxdma_channel #(.ADDR_W(ADDR_W), .NUM_DESC(4), .POLL_CYCLES(POLL)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .poll_kick(poll_kick),
        .ring_base(ring_base), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_word(input int a);
        return {mem_b[a+3], mem_b[a+2], mem_b[a+1], mem_b[a]};
    endfunction

    task automatic wr_word(input int a, input logic [31:0] w);
        {mem_b[a+3], mem_b[a+2], mem_b[a+1], mem_b[a]} = w;
    endtask

    // Memory model and scoreboard monitor: ack after 0..2 cycles.
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                logic [15:0] a;
                logic we, by;
                logic [31:0] wd;
                a = mem_addr; we = mem_we; by = mem_byte; wd = mem_wdata;
                if (!first_seen) begin
                    first_seen = 1'b1; first_addr = a; first_we = we;
                end
                for (int d = 0; d < txn % 3; d++) begin
                    @(negedge clk);
                    check(mem_req && mem_addr == a && mem_wdata == wd, "R10 request hold",
                          {16'b0, mem_addr}, {16'b0, a});
                end
                txn++;
                if (!we) begin
                    mem_rdata = rd_word(a);
                    if (a == RING + 16'h10) slot2_reads++;
                end else if (by) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 unexpected byte store", {a, wd[7:0]}, 32'h0);
                    end else begin
                        logic [23:0] e;
                        e = exp_q.pop_front();
                        check({a, wd[7:0]} == e, "R3/R6 byte store", {8'b0, a, wd[7:0]}, {8'b0, e});
                    end
                    mem_b[a] = wd[7:0];
                end else begin
                    wr_word(a, wd);
                end
                mem_ack = 1'b1;
            end
        end
    end

    // Driver: push the expected store, then hand the byte over.
    task automatic send_run(input int n, input logic [7:0] seed, input logic ends);
        for (int k = 0; k < n; k++) begin
            logic lst;
            lst = ends && (k == n - 1);
            exp_q.push_back({bq_addr[0] + 16'(cur_off), seed + 8'(k)});
            cur_off++;
            if (lst || cur_off == bq_len[0]) begin
                void'(bq_addr.pop_front());
                void'(bq_len.pop_front());
                cur_off = 0;
            end
            @(negedge clk);
            in_valid = 1'b1; in_data = seed + 8'(k); in_last = lst;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
        end
    endtask

    task automatic kick();
        @(negedge clk); poll_kick = 1'b1;
        @(negedge clk); poll_kick = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem_b[i] = 8'h00;
        wr_word(32'h100, 32'h8000_0008); wr_word(32'h104, 32'h200);
        wr_word(32'h108, 32'h8000_0004); wr_word(32'h10C, 32'h240);
        wr_word(32'h110, 32'h0000_0008); wr_word(32'h114, 32'h280);
        wr_word(32'h118, 32'h8000_0008); wr_word(32'h11C, 32'h2C0);
        bq_addr = '{16'h200, 16'h240, 16'h280, 16'h2C0, 16'h200};
        bq_len  = '{8, 4, 8, 8, 3};

        repeat (4) @(negedge clk);
        check(!mem_req && !in_ready, "R1 reset quiet", {30'b0, mem_req, in_ready}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(!mem_req && !in_ready && !first_seen, "R1 disabled quiet", {31'b0, mem_req}, 0);
        enable = 1'b1;
        repeat (8) @(negedge clk);
        check(first_seen && first_addr == RING && !first_we, "R2 first access",
              {15'b0, first_we, first_addr}, {16'b0, RING});

        // Packet inside buffer 0.
        send_run(5, 8'h10, 1'b1);
        repeat (12) @(negedge clk);
        check(rd_word(32'h100) == 32'h4000_0005, "R7 status slot0", rd_word(32'h100), 32'h4000_0005);

        // Packet larger than buffer 1; slot 2 owned by software.
        send_run(4, 8'h40, 1'b0);
        repeat (12) @(negedge clk);
        check(rd_word(32'h108) == 32'h0000_0004, "R8 budget status", rd_word(32'h108), 32'h0000_0004);
        begin
            int r0, hi;
            r0 = slot2_reads; hi = 0;
            for (int c = 0; c < 500; c++) begin
                @(negedge clk);
                if (in_ready) hi++;
            end
            check(hi == 0, "R4 stall while not owned", hi, 0);
            check(slot2_reads - r0 >= 2 && slot2_reads - r0 <= 4, "R4 periodic poll", slot2_reads - r0, 3);
        end
        wr_word(32'h110, 32'h8000_0008);
        kick();
        begin
            int w;
            w = 0;
            while (!in_ready && w < 12) begin @(negedge clk); w++; end
            check(in_ready, "R5 forced poll", w, 12);
        end
        send_run(2, 8'h44, 1'b1);
        repeat (12) @(negedge clk);
        check(rd_word(32'h110) == 32'h4000_0002, "R8 continuation status", rd_word(32'h110), 32'h4000_0002);

        // Packet exactly filling buffer 3.
        send_run(8, 8'h80, 1'b1);
        repeat (20) @(negedge clk);
        check(rd_word(32'h118) == 32'h4000_0008, "R7 exact fill status", rd_word(32'h118), 32'h4000_0008);
        check(!in_ready, "R4 wrapped slot not owned", {31'b0, in_ready}, 0);

        // Re-arm slot 0 after wrap.
        wr_word(32'h100, 32'h8000_0003);
        kick();
        send_run(2, 8'hC0, 1'b1);
        repeat (12) @(negedge clk);
        check(mem_b[32'h200] == 8'hC0 && mem_b[32'h201] == 8'hC1, "R9 wrap to slot0",
              {16'b0, mem_b[32'h201], mem_b[32'h200]}, 32'h0000_C1C0);
        check(rd_word(32'h100) == 32'h4000_0002, "R9 slot0 status", rd_word(32'h100), 32'h4000_0002);
        check(exp_q.size() == 0, "R6 all bytes stored", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule